// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block gathers completion events from a set of DMA channel engines and folds them into a single interrupt request. Every channel signals three kinds of event: half of a package moved, a whole package finished, and a whole descriptor queue finished. Each event kind has a sticky pending flag and an enable flag, so each channel has three of each. Software reaches both kinds of flag through a small word-wide register port.

Each channel owns a four-bit slot in the register words. Events set their flags whether or not they are enabled. Software clears pending flags by writing ones to them, and the interrupt line is a registered OR of every pending flag whose enable is set. Before using the block, software normally clears both enable words and writes all-ones to both pending words, so that it starts from a known state.

Top module: `dmairq_status_top`

## Requirements
- R1: After reset both enable words and both pending words read zero, and `irq` is low.
- R2: An event pulse on channel c sets the pending bit at position 4*(c mod 8)+k of word c/8. Here k is 0 for half-package, 1 for package-end and 2 for queue-end. Word 0 holds channels 0 to 7 and word 1 holds channels 8 to 15.
- R3: A pending bit sets on its event even when its enable bit is clear, and stays set until software clears it.
- R4: A write to a pending word clears each pending bit whose write-data bit is 1. A bit whose write-data bit is 0 is left as it was. A pending bit never drops for any other reason.
- R5: When an event and a clearing write hit the same pending bit in the same cycle, the bit is set after that cycle.
- R6: Enable words are written and read at offsets 0x00 and 0x04, and pending words are read and cleared at offsets 0x10 and 0x14. Read data is combinational from `reg_addr`, and writes take effect at the next clock edge.
- R7: Bit 3 of every four-bit slot is reserved. It always reads zero, in both enable and pending words, whatever is written to it.
- R8: `irq` is a register. It is high in the cycle after a cycle in which at least one pending bit and its enable bit were both set, and low otherwise.
- R9: A write to any other offset changes no state, and a read at any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_half | input | 16 | Per-channel half-package event pulses |
| evt_pkg | input | 16 | Per-channel package-end event pulses |
| evt_queue | input | 16 | Per-channel queue-end event pulses |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that event inputs and register controls are stable around each rising clock edge. They also assume that an event held high for several cycles counts as a new event in every one of those cycles, which is what the one-cycle-before relations in the checker encode. The stimulus changes every input only at the falling edge. It covers both single-cycle pulses and back-to-back events, and it mixes writes to mapped and unmapped offsets with event traffic, including writes that collide with events on the same bit.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

  localparam int SLOT_W      = 4;   // bits per channel slot
  localparam int KIND_HALF   = 0;   // slot bit positions decoded by software
  localparam int KIND_PKG    = 1;
  localparam int KIND_QUEUE  = 2;
  localparam int KIND_RSVD   = 3;
  localparam int EN_OFS      = 'h00;
  localparam int PEND_OFS    = 'h10;
  localparam int WORD_STRIDE = 4;

  // Bits of a register word that belong to a live event kind.
  function automatic logic [31:0] live_word_mask(input int word_w);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < word_w; i++)
      m[i] = ((i % SLOT_W) != KIND_RSVD);
    return m;
  endfunction

  // Byte offset of register word w in a bank starting at base.
  function automatic int word_offset(input int base, input int w);
    return base + w * WORD_STRIDE;
  endfunction

endpackage

// File: rtl/dmairq_event_map.sv
module dmairq_event_map #(
  parameter int NUM_CH = 16,
  localparam int FLAT_W = NUM_CH * dmairq_pkg::SLOT_W
) (
  input  logic [NUM_CH-1:0] evt_half,
  input  logic [NUM_CH-1:0] evt_pkg,
  input  logic [NUM_CH-1:0] evt_queue,
  output logic [FLAT_W-1:0] evt_flat
);
  import dmairq_pkg::*;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
    assign evt_flat[c*SLOT_W + KIND_HALF]  = evt_half[c];
    assign evt_flat[c*SLOT_W + KIND_PKG]   = evt_pkg[c];
    assign evt_flat[c*SLOT_W + KIND_QUEUE] = evt_queue[c];
    assign evt_flat[c*SLOT_W + KIND_RSVD]  = 1'b0;
  end
endmodule

// File: rtl/dmairq_word.sv
module dmairq_word #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_we,
  input  logic              pend_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] evt,
  output logic [WORD_W-1:0] en_q,
  output logic [WORD_W-1:0] pend_q,
  output logic [WORD_W-1:0] clr
);
  import dmairq_pkg::*;

  localparam logic [31:0] LIVE32 = live_word_mask(WORD_W);
  localparam logic [WORD_W-1:0] LIVE = LIVE32[WORD_W-1:0];

  assign clr = pend_we ? (wdata & LIVE) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_we)
        en_q <= wdata & LIVE;
      // set beats clear on a collision
      pend_q <= ((pend_q & ~clr) | evt) & LIVE;
    end
  end
endmodule

// File: rtl/dmairq_decode.sv
module dmairq_decode #(
  parameter int NUM_WORDS = 2,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 8,
  localparam int FLAT_W   = NUM_WORDS * WORD_W
) (
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [FLAT_W-1:0] en_flat,
  input  logic [FLAT_W-1:0] pend_flat,
  output logic [NUM_WORDS-1:0] en_we,
  output logic [NUM_WORDS-1:0] pend_we,
  output logic [WORD_W-1:0] reg_rdata
);
  import dmairq_pkg::*;

  logic [NUM_WORDS-1:0] en_hit;
  logic [NUM_WORDS-1:0] pend_hit;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_dec
    assign en_hit[w]   = (reg_addr == ADDR_W'(word_offset(EN_OFS, w)));
    assign pend_hit[w] = (reg_addr == ADDR_W'(word_offset(PEND_OFS, w)));
    assign en_we[w]    = reg_wr & en_hit[w];
    assign pend_we[w]  = reg_wr & pend_hit[w];
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (en_hit[w])   reg_rdata = reg_rdata | en_flat[w*WORD_W +: WORD_W];
      if (pend_hit[w]) reg_rdata = reg_rdata | pend_flat[w*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/dmairq_irq_gen.sv
module dmairq_irq_gen #(
  parameter int FLAT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAT_W-1:0] en_flat,
  input  logic [FLAT_W-1:0] pend_flat,
  output logic              irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(en_flat & pend_flat);
  end
endmodule

// File: rtl/dmairq_status_top.sv
module dmairq_status_top #(
  parameter int NUM_CH = 16,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 8,
  localparam int CH_PER_WORD = WORD_W / dmairq_pkg::SLOT_W,
  localparam int NUM_WORDS   = (NUM_CH + CH_PER_WORD - 1) / CH_PER_WORD,
  localparam int FLAT_W      = NUM_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic [NUM_CH-1:0] evt_half,
  input  logic [NUM_CH-1:0] evt_pkg,
  input  logic [NUM_CH-1:0] evt_queue,
  output logic              irq
);
  localparam int EVT_W = NUM_CH * dmairq_pkg::SLOT_W;

  logic [EVT_W-1:0]     evt_map;
  logic [FLAT_W-1:0]    evt_flat;
  logic [FLAT_W-1:0]    en_flat;
  logic [FLAT_W-1:0]    pend_flat;
  logic [FLAT_W-1:0]    clr_flat;
  logic [NUM_WORDS-1:0] en_we;
  logic [NUM_WORDS-1:0] pend_we;

  dmairq_event_map #(.NUM_CH(NUM_CH)) map_i (
    .evt_half (evt_half),
    .evt_pkg  (evt_pkg),
    .evt_queue(evt_queue),
    .evt_flat (evt_map)
  );

  if (FLAT_W > EVT_W) begin : g_pad
    assign evt_flat = {{(FLAT_W-EVT_W){1'b0}}, evt_map};
  end else begin : g_nopad
    assign evt_flat = evt_map;
  end

  dmairq_decode #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) dec_i (
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .en_flat  (en_flat),
    .pend_flat(pend_flat),
    .en_we    (en_we),
    .pend_we  (pend_we),
    .reg_rdata(reg_rdata)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    dmairq_word #(.WORD_W(WORD_W)) word_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_we  (en_we[w]),
      .pend_we(pend_we[w]),
      .wdata  (reg_wdata),
      .evt    (evt_flat[w*WORD_W +: WORD_W]),
      .en_q   (en_flat[w*WORD_W +: WORD_W]),
      .pend_q (pend_flat[w*WORD_W +: WORD_W]),
      .clr    (clr_flat[w*WORD_W +: WORD_W])
    );
  end

  dmairq_irq_gen #(.FLAT_W(FLAT_W)) irq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_flat  (en_flat),
    .pend_flat(pend_flat),
    .irq_q    (irq)
  );
endmodule

// File: rtl/dmairq_chk.sv
module dmairq_chk #(
  parameter int FLAT_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FLAT_W-1:0] evt_flat,
  input logic [FLAT_W-1:0] en_flat,
  input logic [FLAT_W-1:0] pend_flat,
  input logic [FLAT_W-1:0] clr_flat,
  input logic              irq
);
  function automatic logic [FLAT_W-1:0] rsvd_bits();
    logic [FLAT_W-1:0] r;
    for (int i = 0; i < FLAT_W; i++) r[i] = ((i % 4) == 3);
    return r;
  endfunction

  localparam logic [FLAT_W-1:0] RSVD = rsvd_bits();

  // R5
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pend_flat & $past(evt_flat)) == $past(evt_flat)));

  // R4
  clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(pend_flat) & ~pend_flat & ~$past(clr_flat)) == '0));

  // R7
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_flat & RSVD) == '0) && ((en_flat & RSVD) == '0));

  // R8
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq == |($past(pend_flat) & $past(en_flat))));
endmodule

bind dmairq_status_top dmairq_chk #(.FLAT_W(FLAT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt_flat (evt_flat),
  .en_flat  (en_flat),
  .pend_flat(pend_flat),
  .clr_flat (clr_flat),
  .irq      (irq)
);

// File: tb/dmairq_status_top_tb_top.sv
`timescale 1ns/1ps
module dmairq_status_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] evt_half = '0, evt_pkg = '0, evt_queue = '0;
  logic        irq;

  always #2.5 clk = ~clk;

  dmairq_status_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_half(evt_half),
    .evt_pkg(evt_pkg), .evt_queue(evt_queue), .irq(irq)
  );

  // behavioural reference state
  bit    m_en[64];
  bit    m_pend[64];
  bit    m_irq;
  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) begin
      if (a == 8'h00) r[b] = m_en[b];
      if (a == 8'h04) r[b] = m_en[32+b];
      if (a == 8'h10) r[b] = m_pend[b];
      if (a == 8'h14) r[b] = m_pend[32+b];
    end
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) begin m_en[i] = 0; m_pend[i] = 0; end
    m_irq = 0;
  endtask

  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                      input logic [15:0] h, input logic [15:0] p, input logic [15:0] q);
    logic [31:0] exp_rd;
    bit nirq;
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    evt_half = h; evt_pkg = p; evt_queue = q;
    #1;
    exp_rd = model_read(a);
    n_vec++;
    if (reg_rdata !== exp_rd || irq !== m_irq) begin
      n_bad++;
      $display("FAIL %s addr=%h rdata=%h exp=%h irq=%b exp=%b",
               cur_req, a, reg_rdata, exp_rd, irq, m_irq);
    end
    @(posedge clk);
    nirq = 0;
    for (int i = 0; i < 64; i++) if (m_pend[i] && m_en[i]) nirq = 1;
    for (int i = 0; i < 64; i++) begin
      int k = i % 4; int ch = i / 4; int w = i / 32; int b = i % 32;
      bit ev; bit clr;
      if (k == 3) continue;
      ev = (k == 0) ? h[ch] : (k == 1) ? p[ch] : q[ch];
      if (wr && a == 8'(4*w)) m_en[i] = wd[b];
      clr = wr && (a == 8'(8'h10 + 4*w)) && wd[b];
      if (ev) m_pend[i] = 1;
      else if (clr) m_pend[i] = 0;
    end
    m_irq = nirq;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, 0);
  endtask

  task automatic rd(input logic [7:0] a);
    step(0, a, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    cur_req = "R1";
    rd(8'h00); rd(8'h04); rd(8'h10); rd(8'h14);

    // R6 enable words read back; R7 reserved bits stay zero
    cur_req = "R6";
    step(1, 8'h00, 32'hFFFF_FFFF, 0, 0, 0);
    step(1, 8'h04, 32'h1234_5678, 0, 0, 0);
    cur_req = "R7";
    rd(8'h00); rd(8'h04);
    step(1, 8'h00, 32'h0, 0, 0, 0);
    step(1, 8'h04, 32'h0, 0, 0, 0);

    // R2 slot placement, R3 latch while disabled (irq stays low)
    cur_req = "R2";
    step(0, 8'h10, 0, 16'h0008, 16'h0200, 16'h8000);
    rd(8'h10); rd(8'h14);
    cur_req = "R3";
    step(0, 8'h14, 0, 16'h0001, 16'h0080, 16'h0100);
    idle(2); rd(8'h10); rd(8'h14);

    // R8 enabling a pending bit raises irq one cycle later
    cur_req = "R8";
    step(1, 8'h04, 32'h0000_0020, 0, 0, 0);
    idle(3);
    step(1, 8'h04, 32'h0, 0, 0, 0);
    idle(2);

    // R4 write-one-to-clear, zeros leave bits
    cur_req = "R4";
    step(1, 8'h10, 32'h0000_0001, 0, 0, 0);
    rd(8'h10);
    step(1, 8'h14, 32'h0000_0000, 0, 0, 0);
    rd(8'h14);
    step(1, 8'h10, 32'hFFFF_FFFF, 0, 0, 0);
    step(1, 8'h14, 32'hFFFF_FFFF, 0, 0, 0);
    rd(8'h10); rd(8'h14);

    // R5 event beats clear on the same bit
    cur_req = "R5";
    step(1, 8'h10, 32'h0000_0002, 0, 16'h0001, 0);
    rd(8'h10);
    step(1, 8'h14, 32'hFFFF_FFFF, 0, 0, 16'h0400);
    rd(8'h14);

    // R9 unmapped offsets
    cur_req = "R9";
    step(1, 8'h08, 32'hFFFF_FFFF, 0, 0, 0);
    step(1, 8'h18, 32'hFFFF_FFFF, 0, 0, 0);
    rd(8'h08); rd(8'h20); rd(8'h00); rd(8'h14);

    // mixed traffic against the model
    cur_req = "R2";
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      case ($urandom_range(0, 5))
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h10;
        3: a = 8'h14; 4: a = 8'h0C; default: a = 8'h10;
      endcase
      step($urandom_range(0, 2) == 0, a, $urandom,
           16'($urandom & $urandom), 16'($urandom & $urandom),
           16'($urandom & $urandom & $urandom));
    end
    idle(3);

    done = 1;
    summary();
    $finish;
  end
endmodule